// File: doc/BRIEF.md
# Buffer Queue Host Register Interface

This block sits between a processor and a packet buffer engine. It turns one processor access, made over a four-phase request/acknowledge port, into a buffer SRAM access or a control register access. Bits of the access address pick side effects. A register write may update several registers at once because each register has its own select bit. A memory write may append a buffer to the transmit queue and bump the transmit count. A register read may collect the next received buffer, which moves the receive pointer along the linked list held in buffer memory.

The control is one state machine. ST_IDLE latches a request and moves to ST_DEC. ST_DEC branches on the region bit and the write flag to ST_REGWR, ST_REGRD, ST_MWR or ST_MRD. ST_MRD moves to ST_MWAIT. ST_REGRD moves to ST_LRD when a reload is asked for and a buffer is pending, and to ST_ACK otherwise. ST_LRD moves to ST_LWAIT. ST_REGWR, ST_MWR, ST_MWAIT and ST_LWAIT all move to ST_ACK. ST_ACK raises the acknowledge for one cycle and moves to ST_DONE, which returns to ST_IDLE once the request is released.

Software sets up the queue pointers, then writes the head pointer and issues the start command. To send a buffer it writes the new buffer number and flags into the link word of the current tail, using an increment write. An interrupt service routine can make one reload read of the status word: that read reports why the interrupt fired and collects the next received buffer.

Top module: `bq_host_if`

## Requirements
- R1: After reset the head, base, receive pointer and count are zero and transmission is stopped. Therefore tx_run=0, rx_en=0, rx_irq=0 (with rx_wr_ptr=0) and tx_space=1.
- R2: rx_en is 1 exactly when the head pointer differs from the base pointer.
- R3: Register-space accesses have haddr[15]=0. On a write, bits [4:0] of the address select registers: bit0 head, bit1 base, bit2 receive pointer, bit3 count, bit4 command. Every selected register takes the data, bits [7:0] for the pointers, in the same access.
- R4: In a command write, data bit0 starts transmission and data bit1 stops it. When both bits are set, stop wins. With neither bit set, tx_run keeps its value.
- R5: A write with haddr[15]=1 and haddr[14]=1 stores hwdata at SRAM word haddr[11:0]. While the count is below QDEPTH (16), the same write adds one to the count. A one-cycle tx_done pulse takes one off a non-zero count. A count write is clamped to QDEPTH.
- R6: tx_space is 1 exactly when the count is below QDEPTH. An increment write made while the count is at QDEPTH leaves the count unchanged but still writes the memory.
- R7: A register read returns the lowest-numbered selected source: bit0 the status word, bit1 head, bit2 base, bit3 count, bit4 {15'b0, tx_run}. The status word is {tx_run, rx_en, tx_space, rx_irq, 4'b0, rxp[7:0]}.
- R8: rx_irq is 1 exactly when the receive pointer differs from rx_wr_ptr. A register read with haddr[8]=1 returns the value held before the access. If rx_irq is 1, the read then loads the receive pointer from bits [7:0] of the link word at SRAM word {rxp, 4'b0000}. If rx_irq is 0, the read changes nothing.
- R9: hack is high for exactly one cycle per access. It comes 3 cycles after the request is sampled for register accesses, memory writes and reloads with nothing pending, 4 cycles for memory reads, and 5 cycles for reloads that advance the pointer.
- R10: A write with haddr[15]=1 and haddr[14]=0 stores to SRAM word haddr[11:0] and leaves the count alone. A read with haddr[15]=1 returns that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hreq | input | 1 | Processor request, held until hack |
| hwr | input | 1 | 1 = write, 0 = read |
| haddr | input | 16 | Access address with region, flag and select bits |
| hwdata | input | 16 | Write data |
| hack | output | 1 | One-cycle acknowledge |
| hrdata | output | 16 | Read data, valid while hack is high |
| mem_en | output | 1 | SRAM enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | 12 | SRAM word address |
| mem_wdata | output | 16 | SRAM write data |
| mem_rdata | input | 16 | SRAM read data, one cycle after an enabled read |
| rx_wr_ptr | input | 8 | Hardware receive write pointer |
| tx_done | input | 1 | Pulse: one queued transmit buffer finished |
| rx_irq | output | 1 | Receive buffer pending |
| rx_en | output | 1 | Reception enabled |
| tx_space | output | 1 | Transmit slot available |
| tx_run | output | 1 | Transmission running |

## Verification
Each processor result is due a fixed number of cycles after the request is sampled. Register writes, memory writes and reloads with nothing pending acknowledge after 3 cycles, memory reads after 4, and reloads that advance the pointer after 5. The driver counts the cycles up to the acknowledge and checks that count against the expected figure for the access type. The monitor compares the returned data with the expected value in the single cycle that hack is high. The level outputs (rx_en, rx_irq, tx_run, tx_space) are sampled only after the acknowledge, or one time step after rx_wr_ptr or tx_done is driven, when the registers they depend on have already settled.

// File: rtl/bq_pkg.sv
package bq_pkg;
    localparam int DW       = 16;
    localparam int NSEL     = 5;
    localparam int A_MEM    = 15;
    localparam int A_INC    = 14;
    localparam int A_RLD    = 8;
    localparam int SEL_HEAD = 0;
    localparam int SEL_BASE = 1;
    localparam int SEL_RXP  = 2;
    localparam int SEL_CNT  = 3;
    localparam int SEL_CMD  = 4;
    localparam int CMD_GO   = 0;
    localparam int CMD_STOP = 1;
    localparam int STB_RUN  = 15;
    localparam int STB_REN  = 14;
    localparam int STB_SPC  = 13;
    localparam int STB_IRQ  = 12;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEC, ST_REGWR, ST_REGRD, ST_MWR,
        ST_MRD, ST_MWAIT, ST_LRD, ST_LWAIT, ST_ACK, ST_DONE
    } bq_state_e;
endpackage

// File: rtl/bq_txcount.sv
module bq_txcount #(
    parameter int QDEPTH = 16,
    parameter int CW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cnt,
    output logic          tx_space
);
    localparam logic [CW-1:0] FULL = CW'(QDEPTH);

    logic inc_ok;
    logic dec_ok;

    assign inc_ok   = inc && (cnt < FULL);
    assign dec_ok   = dec && (cnt != '0);
    assign tx_space = (cnt < FULL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= (ld_val > FULL) ? FULL : ld_val;
        end else begin
            unique case ({inc_ok, dec_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL && inc && !dec && !ld) |=> (cnt == FULL));
    p_inc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < FULL && inc && !dec && !ld) |=> (cnt == CW'($past(cnt) + 1'b1)));
endmodule

// File: rtl/bq_regfile.sv
module bq_regfile
    import bq_pkg::*;
#(
    parameter int BUF_W = 8,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [NSEL-1:0]  sel,
    input  logic [DW-1:0]    wdata,
    input  logic             rxp_load,
    input  logic [BUF_W-1:0] rxp_next,
    input  logic [BUF_W-1:0] rx_wr_ptr,
    input  logic [CW-1:0]    cnt,
    input  logic             tx_space,
    output logic [DW-1:0]    reg_rdata,
    output logic [BUF_W-1:0] rxp,
    output logic             rx_irq,
    output logic             rx_en,
    output logic             tx_run
);
    logic [BUF_W-1:0] head_q;
    logic [BUF_W-1:0] base_q;
    logic [DW-1:0]    stat;
    logic             unused_wdata;

    assign unused_wdata = ^wdata;
    assign rx_irq = (rxp != rx_wr_ptr);
    assign rx_en  = (head_q != base_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            base_q <= '0;
        end else if (reg_wr) begin
            if (sel[SEL_HEAD]) head_q <= wdata[BUF_W-1:0];
            if (sel[SEL_BASE]) base_q <= wdata[BUF_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxp <= '0;
        end else if (reg_wr && sel[SEL_RXP]) begin
            rxp <= wdata[BUF_W-1:0];
        end else if (rxp_load) begin
            rxp <= rxp_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_run <= 1'b0;
        end else if (reg_wr && sel[SEL_CMD]) begin
            if (wdata[CMD_STOP])     tx_run <= 1'b0;
            else if (wdata[CMD_GO])  tx_run <= 1'b1;
        end
    end

    always_comb begin
        stat              = '0;
        stat[STB_RUN]     = tx_run;
        stat[STB_REN]     = rx_en;
        stat[STB_SPC]     = tx_space;
        stat[STB_IRQ]     = rx_irq;
        stat[BUF_W-1:0]   = rxp;
    end

    always_comb begin
        if (sel[0])      reg_rdata = stat;
        else if (sel[1]) reg_rdata = {{(DW-BUF_W){1'b0}}, head_q};
        else if (sel[2]) reg_rdata = {{(DW-BUF_W){1'b0}}, base_q};
        else if (sel[3]) reg_rdata = {{(DW-CW){1'b0}}, cnt};
        else if (sel[4]) reg_rdata = {{(DW-1){1'b0}}, tx_run};
        else             reg_rdata = '0;
    end

    p_stop_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel[SEL_CMD] && wdata[CMD_STOP]) |=> !tx_run);
    p_run_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && sel[SEL_CMD]) |=> $stable(tx_run));
    p_rxp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxp_load && !(reg_wr && sel[SEL_RXP])) |=> $stable(rxp));
endmodule

// File: rtl/bq_host_fsm.sv
module bq_host_fsm
    import bq_pkg::*;
#(
    parameter int BUF_W      = 8,
    parameter int LINK_SHIFT = 4,
    parameter int MAW        = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hreq,
    input  logic             hwr,
    input  logic [DW-1:0]    haddr,
    input  logic [DW-1:0]    hwdata,
    output logic             hack,
    output logic [DW-1:0]    hrdata,
    output logic             mem_en,
    output logic             mem_we,
    output logic [MAW-1:0]   mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [DW-1:0]    reg_rdata,
    input  logic             rx_pending,
    input  logic [BUF_W-1:0] rxp,
    output logic [NSEL-1:0]  sel,
    output logic [DW-1:0]    wdata,
    output logic             reg_wr,
    output logic             inc_pulse,
    output logic             rxp_load,
    output logic [BUF_W-1:0] rxp_next
);
    bq_state_e     state;
    bq_state_e     nxt;
    logic [DW-1:0] a_q;
    logic [DW-1:0] d_q;
    logic [DW-1:0] rd_q;
    logic          wr_q;
    logic          unused_bits;

    assign unused_bits = ^{a_q, mem_rdata};

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            d_q  <= '0;
            wr_q <= 1'b0;
        end else if (state == ST_IDLE && hreq) begin
            a_q  <= haddr;
            d_q  <= hwdata;
            wr_q <= hwr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_q <= '0;
        else if (state == ST_DEC)   rd_q <= '0;
        else if (state == ST_REGRD) rd_q <= reg_rdata;
        else if (state == ST_MWAIT) rd_q <= mem_rdata;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (hreq) nxt = ST_DEC;
            ST_DEC: begin
                if (a_q[A_MEM]) nxt = wr_q ? ST_MWR : ST_MRD;
                else            nxt = wr_q ? ST_REGWR : ST_REGRD;
            end
            ST_REGWR: nxt = ST_ACK;
            ST_REGRD: nxt = (a_q[A_RLD] && rx_pending) ? ST_LRD : ST_ACK;
            ST_MWR:   nxt = ST_ACK;
            ST_MRD:   nxt = ST_MWAIT;
            ST_MWAIT: nxt = ST_ACK;
            ST_LRD:   nxt = ST_LWAIT;
            ST_LWAIT: nxt = ST_ACK;
            ST_ACK:   nxt = ST_DONE;
            ST_DONE:  if (!hreq) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        hack      = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = a_q[MAW-1:0];
        reg_wr    = 1'b0;
        inc_pulse = 1'b0;
        rxp_load  = 1'b0;
        unique case (state)
            ST_REGWR: reg_wr = 1'b1;
            ST_MWR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                inc_pulse = a_q[A_INC];
            end
            ST_MRD:   mem_en = 1'b1;
            ST_LRD: begin
                mem_en   = 1'b1;
                mem_addr = {rxp, {LINK_SHIFT{1'b0}}};
            end
            ST_LWAIT: rxp_load = 1'b1;
            ST_ACK:   hack = 1'b1;
            default: ;
        endcase
    end

    assign hrdata    = rd_q;
    assign mem_wdata = d_q;
    assign wdata     = d_q;
    assign sel       = a_q[NSEL-1:0];
    assign rxp_next  = mem_rdata[BUF_W-1:0];

    p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hack |=> !hack);
    p_we_has_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);
    p_idle_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REGRD && !rx_pending) |=> (state == ST_ACK));
    p_reg_mem_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && mem_en));
endmodule

// File: rtl/bq_host_if.sv
module bq_host_if
    import bq_pkg::*;
#(
    parameter int BUF_W      = 8,
    parameter int LINK_SHIFT = 4,
    parameter int QDEPTH     = 16,
    localparam int MAW       = BUF_W + LINK_SHIFT,
    localparam int CW        = $clog2(QDEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hreq,
    input  logic             hwr,
    input  logic [15:0]      haddr,
    input  logic [15:0]      hwdata,
    output logic             hack,
    output logic [15:0]      hrdata,
    output logic             mem_en,
    output logic             mem_we,
    output logic [MAW-1:0]   mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    input  logic [BUF_W-1:0] rx_wr_ptr,
    input  logic             tx_done,
    output logic             rx_irq,
    output logic             rx_en,
    output logic             tx_space,
    output logic             tx_run
);
    logic [NSEL-1:0]  sel;
    logic [DW-1:0]    wdata;
    logic [DW-1:0]    reg_rdata;
    logic             reg_wr;
    logic             inc_pulse;
    logic             rxp_load;
    logic [BUF_W-1:0] rxp_next;
    logic [BUF_W-1:0] rxp;
    logic [CW-1:0]    cnt;

    bq_host_fsm #(.BUF_W(BUF_W), .LINK_SHIFT(LINK_SHIFT), .MAW(MAW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hreq(hreq), .hwr(hwr), .haddr(haddr),
        .hwdata(hwdata), .hack(hack), .hrdata(hrdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .reg_rdata(reg_rdata), .rx_pending(rx_irq),
        .rxp(rxp), .sel(sel), .wdata(wdata), .reg_wr(reg_wr),
        .inc_pulse(inc_pulse), .rxp_load(rxp_load), .rxp_next(rxp_next)
    );

    bq_regfile #(.BUF_W(BUF_W), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .sel(sel), .wdata(wdata),
        .rxp_load(rxp_load), .rxp_next(rxp_next), .rx_wr_ptr(rx_wr_ptr),
        .cnt(cnt), .tx_space(tx_space), .reg_rdata(reg_rdata), .rxp(rxp),
        .rx_irq(rx_irq), .rx_en(rx_en), .tx_run(tx_run)
    );

    bq_txcount #(.QDEPTH(QDEPTH), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc_pulse), .dec(tx_done),
        .ld(reg_wr && sel[SEL_CNT]), .ld_val(wdata[CW-1:0]),
        .cnt(cnt), .tx_space(tx_space)
    );
endmodule

// File: tb/sim_bq_host_if.sv
module sim_bq_host_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hreq = 1'b0;
    logic        hwr = 1'b0;
    logic [15:0] haddr = '0;
    logic [15:0] hwdata = '0;
    logic        hack;
    logic [15:0] hrdata;
    logic        mem_en;
    logic        mem_we;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [7:0]  rx_wr_ptr = '0;
    logic        tx_done = 1'b0;
    logic        rx_irq;
    logic        rx_en;
    logic        tx_space;
    logic        tx_run;

    int nchk = 0;
    int nerr = 0;

    typedef struct {
        bit          is_rd;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    logic [15:0] sram [4096];

    always #5 clk = ~clk;

    bq_host_if u0 (
        .clk(clk), .rst_n(rst_n), .hreq(hreq), .hwr(hwr), .haddr(haddr),
        .hwdata(hwdata), .hack(hack), .hrdata(hrdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rx_wr_ptr(rx_wr_ptr), .tx_done(tx_done),
        .rx_irq(rx_irq), .rx_en(rx_en), .tx_space(tx_space), .tx_run(tx_run)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) sram[mem_addr] <= mem_wdata;
            else        mem_rdata <= sram[mem_addr];
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] st(bit run, bit en, bit spc, bit irq, logic [7:0] p);
        return {run, en, spc, irq, 4'b0000, p};
    endfunction

    // monitor: pops one expected item per acknowledge
    always @(negedge clk) begin
        item_t it;
        if (hack === 1'b1) begin
            if (sbq.size() == 0) begin
                chk("R9 acknowledge without request", 32'd1, 32'd0);
            end else begin
                it = sbq.pop_front();
                if (it.is_rd) chk(it.tag, {16'h0, hrdata}, {16'h0, it.exp});
            end
        end
    end

    task automatic acc(bit wr, logic [15:0] addr, logic [15:0] data,
                       logic [15:0] exp, int lat_exp, string tag);
        item_t it;
        int lat;
        it.is_rd = !wr;
        it.exp   = exp;
        it.tag   = tag;
        sbq.push_back(it);
        @(negedge clk);
        hreq = 1'b1; hwr = wr; haddr = addr; hwdata = data;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (hack !== 1'b1 && lat < 50);
        chk({tag, " latency"}, 32'(lat), 32'(lat_exp));
        hreq = 1'b0;
        @(negedge clk);
    endtask

    task automatic wreg(logic [4:0] s, logic [15:0] data, string tag);
        acc(1'b1, {11'h0, s}, data, 16'h0, 3, tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) sram[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_run", {31'h0, tx_run}, 32'd0);
        chk("R1 rx_en", {31'h0, rx_en}, 32'd0);
        chk("R1 rx_irq", {31'h0, rx_irq}, 32'd0);
        chk("R1 tx_space", {31'h0, tx_space}, 32'd1);
        chk("R1 hack", {31'h0, hack}, 32'd0);
        acc(1'b0, 16'h0001, 16'h0, st(0, 0, 1, 0, 8'h00), 3, "R1 R7 status after reset");
        acc(1'b0, 16'h0008, 16'h0, 16'h0000, 3, "R1 count after reset");

        // R3 multi-select write, R2 reception enable
        wreg(5'b00011, 16'h0005, "R3 head+base write");
        acc(1'b0, 16'h0002, 16'h0, 16'h0005, 3, "R3 head value");
        acc(1'b0, 16'h0004, 16'h0, 16'h0005, 3, "R3 base value");
        chk("R2 equal pointers", {31'h0, rx_en}, 32'd0);
        wreg(5'b00001, 16'h0009, "R3 head only");
        chk("R2 pointers differ", {31'h0, rx_en}, 32'd1);
        acc(1'b0, 16'h0006, 16'h0, 16'h0009, 3, "R7 lowest select wins");
        acc(1'b0, 16'h0004, 16'h0, 16'h0005, 3, "R3 base untouched");

        // R4 commands
        wreg(5'b10000, 16'h0001, "R4 go");
        chk("R4 go", {31'h0, tx_run}, 32'd1);
        wreg(5'b10000, 16'h0003, "R4 go+stop");
        chk("R4 stop wins", {31'h0, tx_run}, 32'd0);
        wreg(5'b10000, 16'h0001, "R4 go again");
        wreg(5'b10000, 16'h0000, "R4 no bits");
        chk("R4 no bits keeps run", {31'h0, tx_run}, 32'd1);
        acc(1'b0, 16'h0010, 16'h0, 16'h0001, 3, "R7 command read");

        // R5 increment write, R10 plain memory
        acc(1'b1, 16'hC050, 16'h8107, 16'h0, 3, "R5 increment write");
        acc(1'b0, 16'h8050, 16'h0, 16'h8107, 4, "R5 link word stored");
        acc(1'b0, 16'h0008, 16'h0, 16'h0001, 3, "R5 count one");
        acc(1'b1, 16'h8123, 16'h1234, 16'h0, 3, "R10 plain write");
        acc(1'b0, 16'h8123, 16'h0, 16'h1234, 4, "R10 plain read");
        acc(1'b0, 16'h0008, 16'h0, 16'h0001, 3, "R10 count unchanged");

        // R6 fill to depth and overflow
        for (int i = 1; i < 16; i++)
            acc(1'b1, 16'hC200 + 16'(i), 16'(i), 16'h0, 3, "R5 fill");
        chk("R6 no space when full", {31'h0, tx_space}, 32'd0);
        acc(1'b0, 16'h0008, 16'h0, 16'h0010, 3, "R6 count at depth");
        acc(1'b1, 16'hC060, 16'hABCD, 16'h0, 3, "R6 write when full");
        acc(1'b0, 16'h0008, 16'h0, 16'h0010, 3, "R6 count held");
        acc(1'b0, 16'h8060, 16'h0, 16'hABCD, 4, "R6 memory still written");
        @(negedge clk) tx_done = 1'b1;
        @(negedge clk) tx_done = 1'b0;
        #1 chk("R6 space after done", {31'h0, tx_space}, 32'd1);
        acc(1'b0, 16'h0008, 16'h0, 16'h000F, 3, "R5 count after done");

        // R8 reload
        acc(1'b1, 16'h8020, 16'h0007, 16'h0, 3, "R10 link of 2");
        acc(1'b1, 16'h8070, 16'h0009, 16'h0, 3, "R10 link of 7");
        wreg(5'b00100, 16'h0002, "R3 rx pointer write");
        @(negedge clk) rx_wr_ptr = 8'h02;
        #1 chk("R8 irq low when equal", {31'h0, rx_irq}, 32'd0);
        acc(1'b0, 16'h0101, 16'h0, st(1, 1, 1, 0, 8'h02), 3, "R8 reload nothing pending");
        acc(1'b0, 16'h0001, 16'h0, st(1, 1, 1, 0, 8'h02), 3, "R8 pointer kept");
        @(negedge clk) rx_wr_ptr = 8'h09;
        #1 chk("R8 irq high when differ", {31'h0, rx_irq}, 32'd1);
        acc(1'b0, 16'h0101, 16'h0, st(1, 1, 1, 1, 8'h02), 5, "R8 reload pending");
        acc(1'b0, 16'h0001, 16'h0, st(1, 1, 1, 1, 8'h07), 3, "R8 pointer followed link");
        acc(1'b0, 16'h0101, 16'h0, st(1, 1, 1, 1, 8'h07), 5, "R8 second reload");
        chk("R8 irq cleared", {31'h0, rx_irq}, 32'd0);
        acc(1'b0, 16'h0001, 16'h0, st(1, 1, 1, 0, 8'h09), 3, "R8 caught up");

        repeat (2) @(negedge clk);
        chk("R9 all acknowledges seen", 32'(sbq.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule